// File: doc/BRIEF.md
# Queue-Ordered Hardware Lock Controller

This block arbitrates one shared lock among a fixed set of requesters and grants it strictly in the order in which requests arrive. A requester pulses its acquire strobe and is handed a ticket taken from a shared ticket counter, which then advances. Each ticket position has its own one-bit go flag. A requester owns the lock exactly while the flag at its ticket position is set, so the controller never has to scan or broadcast to decide who runs next.

When the owner pulses its release strobe, the flag at its own ticket is cleared and the flag at the next ticket is raised. Only the requester waiting on that next ticket sees a change. Ticket numbers and flag positions wrap around the requester count, which must be a power of two. Storage therefore grows linearly with the number of requesters: one flag and one ticket register per requester.

Top module: `abql_lock`

## Requirements
- R1: After reset the ticket counter is 0, flag 0 is set and all other flags are clear, all grants are low, every ticket output reads 0 and the error output is low; the first requester to acquire therefore receives ticket 0 and is granted in the cycle after its strobe.
- R2: An accepted acquire from an idle requester returns the current counter value as that requester's ticket (visible on its ticket output in the cycle after the strobe) and advances the counter by one.
- R3: When several idle requesters strobe acquire in the same cycle, tickets are handed out in ascending requester-index order, the lowest index getting the current counter value.
- R4: A requester's grant is high only while it holds a ticket and the flag at that ticket is set; at most one grant is high at any time.
- R5: A release from the grant holder clears its own flag, sets the flag at its ticket plus one, drops its grant and clears its ticket output to 0 at the next edge; the holder of the following ticket, if any, is granted in that same cycle.
- R6: Grants are issued in the order in which acquires were accepted (first come, first served).
- R7: Ticket values and flag positions wrap modulo the requester count, so a release of the highest ticket passes the lock to the holder of ticket 0.
- R8: A release strobe from a requester that does not currently hold the grant changes no flag, ticket or grant, and raises the error output for exactly the following cycle.
- R9: A requester keeps its ticket until it releases; an acquire strobe from a requester that already holds a ticket is ignored and does not advance the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| acq_i | input | NREQ | Per-requester acquire strobe |
| rel_i | input | NREQ | Per-requester release strobe |
| grant_o | output | NREQ | Per-requester lock-owned indication |
| ticket_o | output | NREQ*log2(NREQ) | Packed per-requester ticket, requester i in bits [i*TW +: TW] |
| err_o | output | 1 | One-cycle pulse after a release from a non-owner |

## Verification
The bench aims at the cases where a queue lock quietly goes unfair: several acquires in one cycle, where a wrong priority encoder would hand out duplicate or reversed tickets, and the wrap from the highest ticket back to 0, where a design that forgot the modulo would strand the next waiter and never grant it again. It also drives releases from waiting requesters; a design that acted on them would move the lock ahead of its owner or grant two requesters at once. Finally, it sends acquires from requesters that already hold a ticket; a design that honoured them would overwrite a queued ticket and skip a position in the order.

// File: rtl/abql_pkg.sv
package abql_pkg;

    // Per-requester queue membership
    typedef enum logic {
        SLOT_IDLE   = 1'b0,
        SLOT_QUEUED = 1'b1
    } slot_state_e;

    // Decoded release strobe of one requester
    typedef struct packed {
        logic fire;   // legitimate release by the current owner
        logic bad;    // release strobe from a non-owner
    } rel_evt_t;

    localparam int unsigned MIN_REQ = 2;

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/abql_ticket_alloc.sv
module abql_ticket_alloc #(
    parameter int unsigned NREQ = 4,
    parameter int unsigned TW   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NREQ-1:0]          accept,
    output logic [NREQ-1:0][TW-1:0]  give_tkt
);

    logic [TW-1:0] next_q;
    logic [TW-1:0] next_d;

    // Ascending index order: each accepted requester takes the running
    // counter value, which then steps by one (wraps on TW bits).
    always_comb begin
        logic [TW-1:0] run;
        run = next_q;
        for (int i = 0; i < int'(NREQ); i++) begin
            give_tkt[i] = run;
            if (accept[i]) begin
                run = run + 1'b1;
            end
        end
        next_d = run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_q <= '0;
        end else begin
            next_q <= next_d;
        end
    end

endmodule

// File: rtl/abql_flag_array.sv
module abql_flag_array #(
    parameter int unsigned NREQ = 4,
    parameter int unsigned TW   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rel_fire,
    input  logic [TW-1:0]    rel_tkt,
    output logic [NREQ-1:0]  flags
);

    logic [TW-1:0] succ_tkt;
    assign succ_tkt = rel_tkt + 1'b1;

    for (genvar k = 0; k < int'(NREQ); k++) begin : g_flag
        localparam logic [TW-1:0] POS = TW'(k);
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[k] <= (k == 0);
            end else if (rel_fire && (rel_tkt == POS)) begin
                flags[k] <= 1'b0;
            end else if (rel_fire && (succ_tkt == POS)) begin
                flags[k] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/abql_req_slot.sv
module abql_req_slot
    import abql_pkg::*;
#(
    parameter int unsigned NREQ = 4,
    parameter int unsigned TW   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acq,
    input  logic             rel,
    input  logic [TW-1:0]    new_tkt,
    input  logic [NREQ-1:0]  flags,
    output logic             accept,
    output logic             grant,
    output rel_evt_t         evt,
    output logic [TW-1:0]    tkt_o
);

    slot_state_e   st_q;
    logic [TW-1:0] tkt_q;

    always_comb begin
        accept   = acq && (st_q == SLOT_IDLE);
        grant    = (st_q == SLOT_QUEUED) && flags[tkt_q];
        evt.fire = rel && grant;
        evt.bad  = rel && !grant;
        tkt_o    = tkt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SLOT_IDLE;
            tkt_q <= '0;
        end else if (evt.fire) begin
            st_q  <= SLOT_IDLE;
            tkt_q <= '0;
        end else if (accept) begin
            st_q  <= SLOT_QUEUED;
            tkt_q <= new_tkt;
        end
    end

endmodule

// File: rtl/abql_lock.sv
module abql_lock
    import abql_pkg::*;
#(
    parameter int unsigned NREQ = 4,
    localparam int unsigned TW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NREQ-1:0]      acq_i,
    input  logic [NREQ-1:0]      rel_i,
    output logic [NREQ-1:0]      grant_o,
    output logic [NREQ*TW-1:0]   ticket_o,
    output logic                 err_o
);

    if (!is_pow2(NREQ) || (NREQ < MIN_REQ)) begin : g_bad_cfg
        $error("abql_lock: NREQ must be a power of two and at least 2");
    end

    logic [NREQ-1:0]          accept;
    logic [NREQ-1:0][TW-1:0]  give_tkt;
    logic [NREQ-1:0][TW-1:0]  held_tkt;
    logic [NREQ-1:0]          flags;
    rel_evt_t                 evt [NREQ];
    logic                     rel_fire;
    logic [TW-1:0]            rel_tkt;
    logic                     bad_any;
    logic                     err_q;

    abql_ticket_alloc #(.NREQ(NREQ), .TW(TW)) u_alloc (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .give_tkt (give_tkt)
    );

    abql_flag_array #(.NREQ(NREQ), .TW(TW)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .rel_fire (rel_fire),
        .rel_tkt  (rel_tkt),
        .flags    (flags)
    );

    for (genvar i = 0; i < int'(NREQ); i++) begin : g_slot
        abql_req_slot #(.NREQ(NREQ), .TW(TW)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .acq     (acq_i[i]),
            .rel     (rel_i[i]),
            .new_tkt (give_tkt[i]),
            .flags   (flags),
            .accept  (accept[i]),
            .grant   (grant_o[i]),
            .evt     (evt[i]),
            .tkt_o   (held_tkt[i])
        );
        assign ticket_o[i*TW +: TW] = held_tkt[i];
    end

    // Only the single owner can fire, so an OR merge selects its ticket.
    always_comb begin
        rel_fire = 1'b0;
        rel_tkt  = '0;
        bad_any  = 1'b0;
        for (int i = 0; i < int'(NREQ); i++) begin
            if (evt[i].fire) begin
                rel_fire = 1'b1;
                rel_tkt  = rel_tkt | held_tkt[i];
            end
            bad_any = bad_any | evt[i].bad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= bad_any;
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/abql_lock_chk.sv
module abql_lock_chk #(
    parameter int unsigned NREQ = 4,
    parameter int unsigned TW   = 2
) (
    input logic                clk,
    input logic                rst,
    input logic [NREQ-1:0]     acq_i,
    input logic [NREQ-1:0]     rel_i,
    input logic [NREQ-1:0]     grant_o,
    input logic [NREQ*TW-1:0]  ticket_o,
    input logic                err_o
);

    // R4: never two owners
    p_single_owner_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R8: a stray release is reported in the next cycle
    p_stray_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (|(rel_i & ~grant_o)) |=> err_o);

    // R8: no stray release, no error
    p_no_false_err_r8: assert property (@(posedge clk) disable iff (rst)
        !(|(rel_i & ~grant_o)) |=> !err_o);

    // R1: outputs leave reset quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        $fell(rst) |-> (grant_o == '0) && (ticket_o == '0) && !err_o);

    for (genvar i = 0; i < int'(NREQ); i++) begin : g_req
        // R9: owner keeps lock and ticket until it releases
        p_owner_keeps_r9: assert property (@(posedge clk) disable iff (rst)
            (grant_o[i] && !rel_i[i]) |=>
                (grant_o[i] && $stable(ticket_o[i*TW +: TW])));

        // R9: an acquire by an owner does not change its ticket
        p_reacq_ignored_r9: assert property (@(posedge clk) disable iff (rst)
            (acq_i[i] && grant_o[i] && !rel_i[i]) |=>
                $stable(ticket_o[i*TW +: TW]));

        // R5: a release drops the owner's grant and ticket
        p_release_drops_r5: assert property (@(posedge clk) disable iff (rst)
            (rel_i[i] && grant_o[i]) |=>
                (!grant_o[i] && (ticket_o[i*TW +: TW] == '0)));
    end

endmodule

bind abql_lock abql_lock_chk #(.NREQ(NREQ), .TW(TW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .acq_i    (acq_i),
    .rel_i    (rel_i),
    .grant_o  (grant_o),
    .ticket_o (ticket_o),
    .err_o    (err_o)
);

// File: tb/tb_abql_lock.sv
module tb_abql_lock;

    localparam int N          = 4;
    localparam int TW         = 2;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    acq_i = '0;
    logic [N-1:0]    rel_i = '0;
    logic [N-1:0]    grant_o;
    logic [N*TW-1:0] ticket_o;
    logic            err_o;

    abql_lock #(.NREQ(N)) dut (
        .clk      (clk),
        .rst      (rst),
        .acq_i    (acq_i),
        .rel_i    (rel_i),
        .grant_o  (grant_o),
        .ticket_o (ticket_o),
        .err_o    (err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model
    bit busy    [N];
    int exp_tkt [N];
    int next_t  = 0;
    int arr_q   [$];   // current waiting order (driver view)
    int exp_q   [$];   // expected grant order (scoreboard)

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input bit exp_err);
        int eg;
        for (int i = 0; i < N; i++) begin
            int t;
            t = int'(ticket_o[i*TW +: TW]);
            chk(t == exp_tkt[i], req, $sformatf("ticket of req%0d", i), t, exp_tkt[i]);
        end
        eg = (arr_q.size() != 0) ? (1 << arr_q[0]) : 0;
        chk(int'(grant_o) == eg, "R4", "grant vector", int'(grant_o), eg);
        chk(err_o == exp_err, "R8", "error output", int'(err_o), int'(exp_err));
    endtask

    task automatic do_acq(input logic [N-1:0] m, input string req);
        for (int i = 0; i < N; i++) begin
            if (m[i] && !busy[i]) begin
                busy[i]    = 1'b1;
                exp_tkt[i] = next_t;
                next_t     = (next_t + 1) % N;
                arr_q.push_back(i);
                exp_q.push_back(i);
            end
        end
        acq_i = m;
        @(negedge clk);
        acq_i = '0;
        check_all(req, 1'b0);
    endtask

    task automatic do_rel_owner(input string req);
        int h;
        h = arr_q.pop_front();
        busy[h]    = 1'b0;
        exp_tkt[h] = 0;
        rel_i = N'(1 << h);
        @(negedge clk);
        rel_i = '0;
        check_all(req, 1'b0);
    endtask

    task automatic stray_rel(input int r);
        rel_i = N'(1 << r);
        @(negedge clk);
        rel_i = '0;
        check_all("R8", 1'b1);
        @(negedge clk);
        check_all("R8", 1'b0);
    endtask

    // Monitor: every new grant must match the next expected owner (R6)
    logic [N-1:0] prev_grant = '0;
    always @(negedge clk) begin
        if (rst) begin
            prev_grant <= '0;
        end else begin
            logic [N-1:0] rise;
            rise = grant_o & ~prev_grant;
            if (rise != '0) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected grant", int'(rise), 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(rise) == (1 << e), "R6", "grant order", int'(rise), 1 << e);
                end
            end
            prev_grant <= grant_o;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            chk(1'b0, "R6", "watchdog expired", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] masks [4];
        masks[0] = 4'b1010;
        masks[1] = 4'b0101;
        masks[2] = 4'b1111;
        masks[3] = 4'b0110;
        for (int i = 0; i < N; i++) begin
            busy[i]    = 1'b0;
            exp_tkt[i] = 0;
        end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1", 1'b0);              // R1 reset state

        do_acq(4'b0001, "R1");              // R1/R2 first ticket 0, granted
        do_acq(4'b1110, "R3");              // R3 tickets 1,2,3 by index
        stray_rel(2);                       // R8
        stray_rel(3);                       // R8
        do_acq(4'b0001, "R9");              // R9 re-acquire by owner ignored
        do_rel_owner("R5");                 // R5 hand to ticket 1
        do_acq(4'b0001, "R7");              // R7 counter wrapped to 0
        do_rel_owner("R5");
        do_rel_owner("R5");
        do_rel_owner("R7");                 // R7 ticket 3 -> ticket 0
        do_rel_owner("R5");

        for (int r = 0; r < 4; r++) begin
            do_acq(masks[r], "R2");
            if (arr_q.size() != 0) do_rel_owner("R5");
            do_acq(4'b1111, "R3");
            stray_rel(arr_q[arr_q.size() - 1] == arr_q[0] ? (arr_q[0] + 1) % N
                                                          : arr_q[arr_q.size() - 1]);
            while (arr_q.size() != 0) do_rel_owner("R6");
        end

        @(negedge clk);
        chk(exp_q.size() == 0, "R6", "grants still owed", exp_q.size(), 0);
        chk(grant_o == '0, "R4", "idle grant vector", int'(grant_o), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule